// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block runs complete register and serial-EEPROM transfers on an I2C bus by steering a byte-level bit engine below it. A single command supplies a 7-bit device address, a memory address of up to four bytes, an address length from zero to four, a byte count and an opcode (write, read or probe). The sequencer then asks the engine for START, STOP, byte-write and byte-read steps in the right order. Write payload is pulled from a valid/ready input stream. Read payload is pushed out on a valid/ready output stream.

When all steps are done, the sequencer pulses `done` and presents a status code and a count of data bytes the device refused. A read that carries a memory address first sets the device's pointer with an addressing write. It then ends that phase with a full STOP and opens the read phase with a fresh START. Memory-address bits above the transmitted address bytes can be merged into the device address through a mask. This lets a large memory answer as a group of 256-byte devices. The probe opcode gives software a single-byte presence test that it can repeat while waiting for a memory write to finish.

Top module: `i2c_txn_seq`

## Requirements
- R1: A write (opcode 0) produces START, a byte-write of {device,0}, one byte-write per memory-address byte with the most significant byte first, one byte-write per payload byte taken in stream order, then STOP. It finishes with status 0 (OK) when nothing was refused.
- R2: If the device-address byte of a write, read or probe is refused (engine reports NACK), the block issues STOP and nothing else, and it finishes with status 1 (no device).
- R3: A refused payload byte during a write does not end the transfer. Every remaining payload byte is still sent. `fail_cnt` equals the number of refused payload bytes, and the status is 3 when that number is nonzero.
- R4: A read (opcode 1) with an address length above zero produces START, {device,0}, the address bytes with the most significant byte first, STOP, START, {device,1}, then the byte-reads.
- R5: A read with address length zero produces START, then {device,1} at once, with no addressing phase.
- R6: Each byte-read requests ACK (`eng_ack`=0) except the last, which requests NACK (`eng_ack`=1), and STOP follows it. The received bytes appear on `rd_data` in arrival order, and each is held stable with `rd_valid` high until `rd_ready` takes it.
- R7: The device address used on the bus is the command's device address ORed with (memory address shifted right by 8 times the address length) ANDed with the parameter `OVF_MASK` (default 7'h07). A mask of zero turns the merge off.
- R8: A probe (opcode 2 or 3) produces START, {device,0}, STOP. It finishes with status 0 if the byte was acknowledged and status 1 otherwise.
- R9: A refused memory-address byte stops the transfer: STOP is issued at once and the status is 2 (address NACK).
- R10: `busy` is high from the cycle after a command is taken until the cycle `done` pulses. A command presented while `busy` is high is ignored, and `done` is a one-cycle pulse raised only when `busy` has fallen.
- R11: A byte count of zero makes a write send only its addressing phase and STOP. On a read, it makes the block send only START, {device,1} and STOP.
- R12: A step offered to the engine stays offered, with unchanged opcode and byte, until `eng_ready` accepts it. Only one step is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when `busy` is low |
| cmd_op | input | 2 | 0 write, 1 read, 2 or 3 probe |
| cmd_chip | input | 7 | Device address |
| cmd_addr | input | ADDR_W | Memory address (low ALEN bytes sent) |
| cmd_alen | input | ALEN_W | Number of memory-address bytes, 0..MAX_ALEN |
| cmd_len | input | LEN_W | Payload byte count |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read payload byte |
| eng_valid | output | 1 | Step offered to the bit engine |
| eng_ready | input | 1 | Engine accepts the step |
| eng_op | output | 2 | 0 START, 1 STOP, 2 byte-write, 3 byte-read |
| eng_byte | output | 8 | Byte for a byte-write step |
| eng_ack | output | 1 | Level driven after a byte-read (1 = NACK) |
| eng_done | input | 1 | Engine finished the step in flight |
| eng_nack | input | 1 | Byte-write was not acknowledged |
| eng_rdata | input | 8 | Byte received by a byte-read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 OK, 1 no device, 2 address NACK, 3 payload refusals |
| fail_cnt | output | LEN_W | Refused payload bytes of the last write |

## Verification
Properties check the handshake rules on every cycle. They confirm that an engine step and a pending read byte stay frozen until accepted, that work starts only from an offered command, that `done` never coincides with `busy`, and that a nonzero refusal count or a missing device always comes with the matching status. The step order on the bus, the merge of overflow bits into the device address, the ACK/NACK pattern on reads and the early exits on refused address bytes can only be shown by the directed scenarios. In those scenarios a bench model of the engine logs every step and injects NACKs at chosen positions.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        TXN_WRITE = 2'd0,
        TXN_READ  = 2'd1,
        TXN_PROBE = 2'd2,
        TXN_ALT   = 2'd3
    } txn_op_e;

    typedef enum logic [1:0] {
        STS_OK        = 2'd0,
        STS_NODEV     = 2'd1,
        STS_ADDR_NACK = 2'd2,
        STS_DATA_FAIL = 2'd3
    } sts_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START1, PH_CHIPW, PH_ADDR, PH_WDATA, PH_MIDSTOP,
        PH_START2, PH_CHIPR, PH_RDATA, PH_RPUSH, PH_STOP
    } phase_e;

endpackage

// File: rtl/i2c_txn_addr_path.sv
module i2c_txn_addr_path #(
    parameter int          MAX_ALEN = 4,
    parameter int          ALEN_W   = 3,
    parameter logic [6:0]  OVF_MASK = 7'h07,
    localparam int         ADDR_W   = MAX_ALEN * 8
) (
    input  logic [6:0]        chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic [ALEN_W-1:0] idx,
    output logic [6:0]        chip_eff,
    output logic [7:0]        addr_byte
);
    localparam int EXT_W = ADDR_W + 8;

    logic [7:0]       lane [MAX_ALEN];
    logic [EXT_W-1:0] above;

    for (genvar g = 0; g < MAX_ALEN; g++) begin : g_lane
        assign lane[g] = addr[g*8 +: 8];
    end

    // bits above the transmitted address bytes (zero once alen covers all)
    assign above    = {8'h00, addr} >> {alen, 3'b000};
    assign chip_eff = chip | (above[6:0] & OVF_MASK);

    always_comb begin
        addr_byte = 8'h00;
        for (int k = 0; k < MAX_ALEN; k++) begin
            if (idx == ALEN_W'(k)) addr_byte = lane[k];
        end
    end
endmodule

// File: rtl/i2c_txn_eng_map.sv
module i2c_txn_eng_map
    import i2c_txn_pkg::*;
(
    input  phase_e     phase,
    input  logic       waiting,
    input  logic       have_byte,
    input  logic       last,
    input  logic [6:0] chip_eff,
    input  logic [7:0] addr_byte,
    input  logic [7:0] pay_byte,
    output logic       eng_valid,
    output eng_op_e    eng_op,
    output logic [7:0] eng_byte,
    output logic       eng_ack
);
    always_comb begin
        eng_valid = 1'b0;
        eng_op    = ENG_START;
        eng_byte  = 8'h00;
        eng_ack   = 1'b0;
        unique case (phase)
            PH_START1, PH_START2: begin
                eng_valid = !waiting;
                eng_op    = ENG_START;
            end
            PH_MIDSTOP, PH_STOP: begin
                eng_valid = !waiting;
                eng_op    = ENG_STOP;
            end
            PH_CHIPW: begin
                eng_valid = !waiting;
                eng_op    = ENG_WRITE;
                eng_byte  = {chip_eff, 1'b0};
            end
            PH_CHIPR: begin
                eng_valid = !waiting;
                eng_op    = ENG_WRITE;
                eng_byte  = {chip_eff, 1'b1};
            end
            PH_ADDR: begin
                eng_valid = !waiting;
                eng_op    = ENG_WRITE;
                eng_byte  = addr_byte;
            end
            PH_WDATA: begin
                eng_valid = !waiting && have_byte;
                eng_op    = ENG_WRITE;
                eng_byte  = pay_byte;
            end
            PH_RDATA: begin
                eng_valid = !waiting;
                eng_op    = ENG_READ;
                eng_ack   = last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_txn_pkg::*;
#(
    parameter int         MAX_ALEN = 4,
    parameter int         LEN_W    = 8,
    parameter logic [6:0] OVF_MASK = 7'h07,
    localparam int        ADDR_W   = MAX_ALEN * 8,
    localparam int        ALEN_W   = $clog2(MAX_ALEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ALEN_W-1:0] cmd_alen,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_byte,
    output logic              eng_ack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  fail_cnt
);
    typedef struct packed {
        phase_e            phase;
        logic              waiting;
        txn_op_e           op;
        logic [6:0]        chip;
        logic [ADDR_W-1:0] addr;
        logic [ALEN_W-1:0] alen;
        logic [ALEN_W-1:0] idx;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  fail;
        logic [7:0]        pay;
        logic              have_byte;
        logic [7:0]        rbyte;
        sts_e              sts;
        logic              done;
    } seq_state_t;

    seq_state_t q, d;
    logic [6:0] chip_eff;
    logic [7:0] addr_byte;
    logic       last;
    eng_op_e    eng_op_w;
    phase_e     after_addr;

    i2c_txn_addr_path #(
        .MAX_ALEN (MAX_ALEN),
        .ALEN_W   (ALEN_W),
        .OVF_MASK (OVF_MASK)
    ) u_addr (
        .chip      (q.chip),
        .addr      (q.addr),
        .alen      (q.alen),
        .idx       (q.idx),
        .chip_eff  (chip_eff),
        .addr_byte (addr_byte)
    );

    assign last = (q.cnt == LEN_W'(1));

    i2c_txn_eng_map u_map (
        .phase     (q.phase),
        .waiting   (q.waiting),
        .have_byte (q.have_byte),
        .last      (last),
        .chip_eff  (chip_eff),
        .addr_byte (addr_byte),
        .pay_byte  (q.pay),
        .eng_valid (eng_valid),
        .eng_op    (eng_op_w),
        .eng_byte  (eng_byte),
        .eng_ack   (eng_ack)
    );

    assign eng_op   = eng_op_w;
    assign wr_ready = (q.phase == PH_WDATA) && !q.have_byte && !q.waiting;
    assign rd_valid = (q.phase == PH_RPUSH);
    assign rd_data  = q.rbyte;
    assign busy     = (q.phase != PH_IDLE);
    assign done     = q.done;
    assign status   = q.sts;
    assign fail_cnt = q.fail;

    // where the flow goes once the memory address is out
    assign after_addr = (q.op == TXN_READ)     ? PH_MIDSTOP :
                        (q.cnt == '0)          ? PH_STOP    : PH_WDATA;

    always_comb begin
        d      = q;
        d.done = 1'b0;

        unique case (q.phase)
            PH_IDLE: if (cmd_valid) begin
                d.phase     = PH_START1;
                d.op        = (cmd_op == 2'd3) ? TXN_PROBE : txn_op_e'(cmd_op);
                d.chip      = cmd_chip;
                d.addr      = cmd_addr;
                d.alen      = cmd_alen;
                d.cnt       = cmd_len;
                d.fail      = '0;
                d.sts       = STS_OK;
                d.have_byte = 1'b0;
                d.waiting   = 1'b0;
            end
            PH_RPUSH: if (rd_ready) begin
                if (last) d.phase = PH_STOP;
                else begin
                    d.cnt   = q.cnt - LEN_W'(1);
                    d.phase = PH_RDATA;
                end
            end
            default: ;
        endcase

        if (wr_valid && wr_ready) begin
            d.pay       = wr_data;
            d.have_byte = 1'b1;
        end

        if (eng_valid && eng_ready) d.waiting = 1'b1;

        if (q.waiting && eng_done) begin
            d.waiting = 1'b0;
            unique case (q.phase)
                PH_START1:
                    d.phase = (q.op == TXN_READ && q.alen == '0) ? PH_CHIPR : PH_CHIPW;
                PH_CHIPW:
                    if (eng_nack) begin
                        d.sts   = STS_NODEV;
                        d.phase = PH_STOP;
                    end else if (q.op == TXN_PROBE) d.phase = PH_STOP;
                    else if (q.alen != '0) begin
                        d.idx   = q.alen - ALEN_W'(1);
                        d.phase = PH_ADDR;
                    end else d.phase = after_addr;
                PH_ADDR:
                    if (eng_nack) begin
                        d.sts   = STS_ADDR_NACK;
                        d.phase = PH_STOP;
                    end else if (q.idx == '0) d.phase = after_addr;
                    else d.idx = q.idx - ALEN_W'(1);
                PH_WDATA: begin
                    d.have_byte = 1'b0;
                    d.fail      = q.fail + LEN_W'(eng_nack);
                    if (last) d.phase = PH_STOP;
                    else d.cnt = q.cnt - LEN_W'(1);
                end
                PH_MIDSTOP: d.phase = PH_START2;
                PH_START2:  d.phase = PH_CHIPR;
                PH_CHIPR:   d.phase = (q.cnt == '0) ? PH_STOP : PH_RDATA;
                PH_RDATA: begin
                    d.rbyte = eng_rdata;
                    d.phase = PH_RPUSH;
                end
                PH_STOP: begin
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                    if (q.sts == STS_OK && q.fail != '0) d.sts = STS_DATA_FAIL;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12: an offered engine step is frozen until accepted
    p_eng_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_byte) && $stable(eng_ack));

    // R6: a pending read byte is held until taken
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R10: work begins only from an offered command
    p_busy_from_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R10: completion pulse only once idle again
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: refusals always reported through the status code
    p_fail_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && fail_cnt != '0 |-> status == STS_DATA_FAIL);

    // R2: a missing device never carries a payload refusal count
    p_nodev_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == STS_NODEV |-> fail_cnt == '0);

endmodule

// File: tb/test_i2c_txn_seq.sv
`timescale 1ns/1ps
module test_i2c_txn_seq;
    localparam int LEN_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [6:0]  cmd_chip = '0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_alen = '0;
    logic [7:0]  cmd_len = '0;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        eng_valid;
    logic        eng_ready = 1'b0;
    logic [1:0]  eng_op;
    logic [7:0]  eng_byte;
    logic        eng_ack;
    logic        eng_done = 1'b0;
    logic        eng_nack = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic [7:0]  fail_cnt;

    always #4 clk = ~clk;

    i2c_txn_seq i_i2c_txn_seq (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_chip, .cmd_addr, .cmd_alen, .cmd_len,
        .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data,
        .eng_valid, .eng_ready, .eng_op, .eng_byte, .eng_ack, .eng_done, .eng_nack,
        .eng_rdata, .busy, .done, .status, .fail_cnt
    );

    int checks = 0;
    int errors = 0;

    // engine model state and log: entry = {op, ack, byte}
    logic [10:0] log_e [64];
    logic [10:0] exp_e [64];
    int          n_log = 0;
    int          n_exp = 0;
    logic [63:0] nack_mask = '0;
    bit          m_busy = 0;
    bit          m_seen = 0;
    int          m_dly = 0;
    int          m_idx = 0;

    // payload source and sink
    logic [7:0]  wr_buf [8];
    int          wr_idx = 0;
    bit          wr_take = 0;
    logic [7:0]  rd_log [8];
    int          n_rd = 0;
    int          rd_stall = 0;

    sts_capture: begin end

    logic [1:0] got_sts;
    logic [7:0] got_fail;

    task automatic check_eq(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_all();
    end

    // bit-engine model
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_ready = 1'b0;
            if (m_busy) begin
                if (m_dly == 0) begin
                    eng_done  = 1'b1;
                    eng_nack  = nack_mask[m_idx];
                    eng_rdata = 8'hA0 + 8'(m_idx);
                    m_busy    = 0;
                end else m_dly--;
            end else if (eng_valid) begin
                if (n_log[0] && !m_seen) m_seen = 1;
                else begin
                    m_seen = 0;
                    eng_ready = 1'b1;
                    m_idx = n_log;
                    log_e[n_log] = {eng_op, (eng_op == 2'd3) ? eng_ack : 1'b0,
                                    (eng_op == 2'd2) ? eng_byte : 8'h00};
                    n_log++;
                    m_busy = 1;
                    m_dly  = 1;
                end
            end
        end
    end

    // payload streams
    initial begin
        forever begin
            @(negedge clk);
            if (wr_take) wr_idx++;
            wr_data = wr_buf[wr_idx[2:0]];
            wr_take = wr_valid && wr_ready;
            rd_ready = (rd_stall == 0);
            if (rd_stall > 0) rd_stall--;
            if (rd_valid && rd_ready) begin
                rd_log[n_rd[2:0]] = rd_data;
                n_rd++;
            end
        end
    end

    function automatic void ex(int op, int ack, int b);
        exp_e[n_exp] = {op[1:0], ack[0], b[7:0]};
        n_exp++;
    endfunction

    task automatic run(int op, int chip, int addr, int alen, int len, logic [63:0] nm);
        @(negedge clk);
        n_log = 0; n_exp = 0; n_rd = 0; wr_idx = 0; wr_take = 0;
        wr_data = wr_buf[0];
        nack_mask = nm;
        cmd_op = 2'(op); cmd_chip = 7'(chip); cmd_addr = 32'(addr);
        cmd_alen = 3'(alen); cmd_len = 8'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        got_sts  = status;
        got_fail = fail_cnt;
    endtask

    task automatic check_seq(string req);
        bit ok = (n_log == n_exp);
        int bad = -1;
        for (int i = 0; i < n_exp && ok; i++) begin
            if (log_e[i] != exp_e[i]) begin ok = 0; bad = i; end
        end
        checks++;
        if (!ok) begin
            errors++;
            if (bad < 0)
                $display("FAIL %s step count: actual %0d expected %0d", req, n_log, n_exp);
            else
                $display("FAIL %s step %0d: actual %03h expected %03h", req, bad, log_e[bad], exp_e[bad]);
        end
    endtask

    task automatic t_reset();
        check_eq("R10", "busy after reset", busy, 0);
        check_eq("R10", "done after reset", done, 0);
        check_eq("R12", "eng_valid after reset", eng_valid, 0);
        check_eq("R6", "rd_valid after reset", rd_valid, 0);
    endtask

    task automatic t_write_ok();
        run(0, 'h50, 'h0123, 2, 3, '0);
        ex(0,0,0); ex(2,0,'hA0); ex(2,0,'h01); ex(2,0,'h23);
        ex(2,0,'h11); ex(2,0,'h22); ex(2,0,'h33); ex(1,0,0);
        check_seq("R1");
        check_eq("R1", "write status", got_sts, 0);
        check_eq("R1", "write fail count", got_fail, 0);
    endtask

    task automatic t_nodev();
        run(0, 'h50, 'h0123, 2, 3, 64'h2);
        ex(0,0,0); ex(2,0,'hA0); ex(1,0,0);
        check_seq("R2");
        check_eq("R2", "no-device status", got_sts, 1);
    endtask

    task automatic t_data_nack();
        run(0, 'h50, 'h0123, 2, 3, 64'h50);
        ex(0,0,0); ex(2,0,'hA0); ex(2,0,'h01); ex(2,0,'h23);
        ex(2,0,'h11); ex(2,0,'h22); ex(2,0,'h33); ex(1,0,0);
        check_seq("R3");
        check_eq("R3", "refusal status", got_sts, 3);
        check_eq("R3", "refusal count", got_fail, 2);
    endtask

    task automatic t_addr_nack();
        run(0, 'h50, 'h0123, 2, 3, 64'h4);
        ex(0,0,0); ex(2,0,'hA0); ex(2,0,'h01); ex(1,0,0);
        check_seq("R9");
        check_eq("R9", "address nack status", got_sts, 2);
    endtask

    task automatic t_read_addr();
        rd_stall = 4;
        run(1, 'h50, 'h0234, 1, 3, '0);
        // R7: bit 9..8 of the address (2) folded into the device address
        ex(0,0,0); ex(2,0,'hA4); ex(2,0,'h34); ex(1,0,0); ex(0,0,0);
        ex(2,0,'hA5); ex(3,0,0); ex(3,0,0); ex(3,1,0); ex(1,0,0);
        check_seq("R4 R6 R7");
        check_eq("R6", "read count", n_rd, 3);
        check_eq("R6", "read byte 0", rd_log[0], 'hA6);
        check_eq("R6", "read byte 2", rd_log[2], 'hA8);
        check_eq("R4", "read status", got_sts, 0);
    endtask

    task automatic t_read_direct();
        run(1, 'h1C, 0, 0, 2, '0);
        ex(0,0,0); ex(2,0,'h39); ex(3,0,0); ex(3,1,0); ex(1,0,0);
        check_seq("R5");
        check_eq("R5", "direct read byte 1", rd_log[1], 'hA3);
    endtask

    task automatic t_fold_off_wide();
        // two address bytes cover the whole value: nothing to fold (R7)
        run(2, 'h50, 'hFFFF, 2, 0, '0);
        ex(0,0,0); ex(2,0,'hA0); ex(1,0,0);
        check_seq("R7 R8");
        check_eq("R8", "probe present status", got_sts, 0);
    endtask

    task automatic t_probe_absent();
        run(3, 'h3F, 0, 0, 0, 64'h2);
        ex(0,0,0); ex(2,0,'h7E); ex(1,0,0);
        check_seq("R8");
        check_eq("R8", "probe absent status", got_sts, 1);
    endtask

    task automatic t_zero_len();
        run(0, 'h50, 'h05, 1, 0, '0);
        ex(0,0,0); ex(2,0,'hA0); ex(2,0,'h05); ex(1,0,0);
        check_seq("R11 write");
        run(1, 'h50, 0, 0, 0, '0);
        n_exp = 0;
        ex(0,0,0); ex(2,0,'hA1); ex(1,0,0);
        check_seq("R11 read");
        check_eq("R11", "zero-length read bytes", n_rd, 0);
    endtask

    task automatic t_busy_block();
        @(negedge clk);
        n_log = 0; n_exp = 0; nack_mask = '0;
        cmd_op = 2'd2; cmd_chip = 7'h22; cmd_alen = '0; cmd_len = '0;
        cmd_valid = 1'b1;
        @(negedge clk);
        check_eq("R10", "busy after accept", busy, 1);
        cmd_op = 2'd0; cmd_chip = 7'h11;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        check_eq("R10", "busy at done", busy, 0);
        repeat (4) @(negedge clk);
        ex(0,0,0); ex(2,0,'h44); ex(1,0,0);
        check_seq("R10");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) wr_buf[i] = 8'h11 * 8'(i + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ok();
        t_nodev();
        t_data_nack();
        t_addr_nack();
        t_read_addr();
        t_read_direct();
        t_fold_off_wide();
        t_probe_absent();
        t_zero_len();
        t_busy_block();
        repeat (4) @(negedge clk);
        finish_all();
    end
endmodule